// File: doc/BRIEF.md
# Synchronous SRAM Core with Selectable Read Pipeline

This block is a synthesizable model of a single-port synchronous static RAM. Address, write data, the three chip enables and the write controls are all sampled on the rising clock edge. A write can store the whole word or only selected bytes. A read returns the stored word on a data-out bus, and a separate drive flag stands in for the enable of a tri-state output.

A static mode input picks how read data reaches the bus. In flow-through mode the word follows the registered address straight out of the array. In pipelined mode the word passes through one more output register first. Any cycle that is not a read turns the drive flag off after the same number of edges as a read takes to show its data. For this purpose a write, a deselected cycle and a sleep cycle all count as non-reads. This is dual-cycle deselect in pipelined mode.

Output enable and sleep act on the outputs without waiting for a clock edge. While sleep is high, the core performs no operation and keeps its contents. The array holds 2**ADDR_W words of DATA_W bits. A full-size part uses ADDR_W = 16 and DATA_W = 32, giving 65,536 words and 2,097,152 bits. The default ADDR_W is 10 so that elaboration stays small. The address comes in already generated, so there is no burst counter.

Top module: `sram_sync_core`

## Requirements
- R1: A word written at an address is returned unchanged by a later read of that address, for any address below 2**ADDR_W.
- R2: The core is selected only when chip_en_a_n = 0, chip_en_b = 1 and chip_en_c_n = 0. In any other combination, the cycle neither writes nor reads.
- R3: With all_wr_n = 1 and byte_wr_n = 0, only byte i (wdata bits 8i+7..8i) is written, and only for each i where byte_sel_n[i] = 0. The other bytes keep their old value.
- R4: With all_wr_n = 0, all bytes are written whatever the values of byte_wr_n and byte_sel_n.
- R5: With pipe_sel = 0, a read sampled at edge k drives its data on rdata, with rdata_drive = 1, from just after edge k until edge k+1.
- R6: With pipe_sel = 1, a read sampled at edge k drives its data from just after edge k+1 until edge k+2.
- R7: A non-read cycle sampled at edge k turns rdata_drive off at the same read depth: after edge k in flow-through mode, and after edge k+1 in pipelined mode. Non-read cycles are writes, deselects and sleep cycles.
- R8: rdata_drive is 1 only while out_en_n = 0, and it reacts to out_en_n without a clock edge. Whenever rdata_drive is 0, rdata is zero.
- R9: While sleep = 1, the outputs stop driving at once, no write or read is performed, and the stored contents are kept.
- R10: After a clock edge with rst_n = 0, rdata_drive is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the read pipeline |
| pipe_sel | input | 1 | Static mode: 0 = flow-through, 1 = pipelined |
| chip_en_a_n | input | 1 | Chip enable, active low |
| chip_en_b | input | 1 | Chip enable, active high |
| chip_en_c_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| byte_sel_n | input | DATA_W/8 | Per-byte write selects, active low |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| all_wr_n | input | 1 | Whole-word write enable, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep request, asynchronous |
| rdata | output | DATA_W | Read data, zero when not driven |
| rdata_drive | output | 1 | High while rdata is being driven |

## Verification
The clocked latency properties assume that pipe_sel is held constant outside reset, since it is a strap and not a per-cycle control. The bench changes pipe_sel only while rst_n is low and runs one full phase in each mode. The bench changes inputs on the falling edge, so sleep and the selects are stable at each sampling edge. The asynchronous effects of out_en_n and sleep are tested by changing them in mid-cycle and sampling shortly afterwards. Random traffic stays within a small set of addresses that are written first, so no read ever returns an unwritten word.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

  // Chip is selected only with the one legal enable combination.
  function automatic logic chip_sel(input logic en_a_n, input logic en_b,
                                    input logic en_c_n);
    return !en_a_n && en_b && !en_c_n;
  endfunction

  // Classify a sampled cycle; writes take precedence over reads.
  function automatic sram_op_e classify(input logic sel, input logic sleep,
                                        input logic all_wr_n,
                                        input logic byte_wr_n);
    if (!sel || sleep)                return OP_IDLE;
    else if (!all_wr_n || !byte_wr_n) return OP_WRITE;
    else                              return OP_READ;
  endfunction

endpackage

// File: rtl/sram_cmd_dec.sv
module sram_cmd_dec #(
  parameter int NB = 4
) (
  input  logic          en_a_n,
  input  logic          en_b,
  input  logic          en_c_n,
  input  logic          all_wr_n,
  input  logic          byte_wr_n,
  input  logic [NB-1:0] byte_sel_n,
  input  logic          sleep,
  output logic          selected,
  output logic          rd_fire,
  output logic          wr_fire,
  output logic [NB-1:0] wr_mask
);
  import sram_pkg::*;

  sram_op_e op;

  always_comb begin
    selected = chip_sel(en_a_n, en_b, en_c_n);
    op       = classify(selected, sleep, all_wr_n, byte_wr_n);
    rd_fire  = (op == OP_READ);
    wr_fire  = (op == OP_WRITE);
    wr_mask  = '0;
    if (op == OP_WRITE) begin
      // whole-word write is checked ahead of the byte path
      if (!all_wr_n) wr_mask = '1;
      else           wr_mask = ~byte_sel_n;
    end
  end

endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic [DATA_W/8-1:0] wr_mask,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]   raddr,
  output logic [DATA_W-1:0]   rdata
);
  localparam int NB    = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (wr_mask[b]) mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sram_rd_pipe.sv
module sram_rd_pipe #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_sel,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] arr_q,
  input  logic              out_en_n,
  input  logic              sleep,
  output logic [ADDR_W-1:0] raddr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drive
);
  logic              v1_q, v2_q;
  logic [ADDR_W-1:0] a1_q;
  logic [DATA_W-1:0] d2_q;
  logic [DATA_W-1:0] data_sel;

  // Stage one registers the command; stage two is the output register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= rd_fire;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_fire) a1_q <= addr;
    d2_q <= arr_q;
  end

  assign raddr = a1_q;

  always_comb begin
    rd_valid    = pipe_sel ? v2_q : v1_q;
    data_sel    = pipe_sel ? d2_q : arr_q;
    rdata_drive = rd_valid && !out_en_n && !sleep;
    rdata       = rdata_drive ? data_sel : '0;
  end

endmodule

// File: rtl/sram_sync_core.sv
module sram_sync_core #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pipe_sel,
  input  logic                chip_en_a_n,
  input  logic                chip_en_b,
  input  logic                chip_en_c_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] byte_sel_n,
  input  logic                byte_wr_n,
  input  logic                all_wr_n,
  input  logic                out_en_n,
  input  logic                sleep,
  output logic [DATA_W-1:0]   rdata,
  output logic                rdata_drive
);
  localparam int NB = DATA_W / 8;

  logic              selected, rd_fire, wr_fire, rd_valid;
  logic [NB-1:0]     wr_mask;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] arr_q;

  sram_cmd_dec #(.NB(NB)) dec_i (
    .en_a_n(chip_en_a_n), .en_b(chip_en_b), .en_c_n(chip_en_c_n),
    .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .byte_sel_n(byte_sel_n),
    .sleep(sleep), .selected(selected), .rd_fire(rd_fire),
    .wr_fire(wr_fire), .wr_mask(wr_mask)
  );

  sram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .wr_mask(wr_mask), .waddr(addr), .wdata(wdata),
    .raddr(raddr), .rdata(arr_q)
  );

  sram_rd_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pipe_i (
    .clk(clk), .rst_n(rst_n), .pipe_sel(pipe_sel), .rd_fire(rd_fire),
    .addr(addr), .arr_q(arr_q), .out_en_n(out_en_n), .sleep(sleep),
    .raddr(raddr), .rd_valid(rd_valid), .rdata(rdata),
    .rdata_drive(rdata_drive)
  );

  // R2: no command while deselected
  a_r2_desel_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |-> !rd_fire && !wr_fire);

  // R4: whole-word write covers every byte lane
  a_r4_all_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !sleep && !all_wr_n) |-> (wr_fire && (&wr_mask)));

  // R5: flow-through read valid right after the sampling edge
  a_r5_flow_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_sel && rd_fire) |=> rd_valid);

  // R6: pipelined read valid one edge later
  a_r6_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_sel && rd_fire) |=> ##1 rd_valid);

  // R7: deselect turns off at the read depth of each mode
  a_r7_flow_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_sel && !rd_fire) |=> !rd_valid);
  a_r7_pipe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_sel && !rd_fire) |=> ##1 !rd_valid);

  // R8: bus quiet unless output enable is low
  a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en_n || !rdata_drive) |-> (!rdata_drive && rdata == '0));

  // R9: sleep blocks every operation
  a_r9_sleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rd_fire && !wr_fire && !rdata_drive);

endmodule

// File: tb/sram_sync_core_tb.sv
module sram_sync_core_tb_top;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n, pipe_sel, ce_a_n, ce_b, ce_c_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [NB-1:0] bsel_n;
  logic          bwr_n, awr_n, oe_n, slp;
  logic [DW-1:0] rdata;
  logic          rdrive;

  int total = 0;
  int bad   = 0;

  // bench model
  logic [DW-1:0] mdl [0:15];
  logic          m_v1, m_v2;
  logic [AW-1:0] m_a1;
  logic [DW-1:0] m_d2;

  always #5 clk = ~clk;

  sram_sync_core #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pipe_sel(pipe_sel), .chip_en_a_n(ce_a_n),
    .chip_en_b(ce_b), .chip_en_c_n(ce_c_n), .addr(addr), .wdata(wdata),
    .byte_sel_n(bsel_n), .byte_wr_n(bwr_n), .all_wr_n(awr_n),
    .out_en_n(oe_n), .sleep(slp), .rdata(rdata), .rdata_drive(rdrive)
  );

  function automatic logic [NB-1:0] lanes(input logic a_n, input logic b_n,
                                          input logic [NB-1:0] s_n);
    if (!a_n)      return '1;
    else if (!b_n) return ~s_n;
    else           return '0;
  endfunction

  task automatic model_edge();
    logic          sel, rd;
    logic [NB-1:0] m;
    logic [DW-1:0] old;
    sel = !ce_a_n && ce_b && !ce_c_n && !slp;
    rd  = sel && awr_n && bwr_n;
    m   = sel ? lanes(awr_n, bwr_n, bsel_n) : '0;
    old = mdl[m_a1[3:0]];
    if (!rst_n) begin
      m_v1 = 1'b0;
      m_v2 = 1'b0;
    end else begin
      m_v2 = m_v1;
      m_v1 = rd;
    end
    m_d2 = old;
    for (int b = 0; b < NB; b++)
      if (m[b]) mdl[addr[3:0]][b*8 +: 8] = wdata[b*8 +: 8];
    if (rd) m_a1 = addr;
  endtask

  task automatic check_out(input string tag);
    logic          ev, edrv;
    logic [DW-1:0] ed, er;
    ev   = pipe_sel ? m_v2 : m_v1;
    ed   = pipe_sel ? m_d2 : mdl[m_a1[3:0]];
    edrv = ev && !oe_n && !slp;
    er   = edrv ? ed : '0;
    total++;
    if (rdrive !== edrv || rdata !== er) begin
      bad++;
      $display("FAIL %s: drive=%0b rdata=%h expected drive=%0b rdata=%h",
               tag, rdrive, rdata, edrv, er);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    #1 check_out(tag);
    @(negedge clk);
  endtask

  task automatic idle_in();
    ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
    bwr_n = 1'b1; awr_n = 1'b1; bsel_n = '1;
    oe_n = 1'b0; slp = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic op_write(input int a, input logic [DW-1:0] d, input string tag);
    addr = AW'(a); wdata = d; awr_n = 1'b0; bwr_n = 1'b1;
    cyc(tag);
    awr_n = 1'b1;
  endtask

  task automatic op_read(input int a, input string tag);
    addr = AW'(a); awr_n = 1'b1; bwr_n = 1'b1;
    cyc(tag);
  endtask

  task automatic run_mode(input logic mode);
    string lt;
    lt = mode ? "R6" : "R5";
    @(negedge clk);
    idle_in();
    rst_n = 1'b0; pipe_sel = mode;
    m_a1 = '0;
    cyc("R10"); cyc("R10");
    rst_n = 1'b1;
    // fill
    for (int i = 0; i < 16; i++) op_write(i, $urandom(), "R1");
    for (int i = 0; i < 16; i++) op_read(i, "R1");
    op_read(0, lt); op_read(5, lt);
    // R3 byte writes: lanes 0 and 2
    addr = AW'(4); wdata = 32'hA1B2C3D4; bwr_n = 1'b0; bsel_n = 4'b1010;
    cyc("R3");
    bwr_n = 1'b0; bsel_n = 4'b1111; addr = AW'(6); cyc("R3");
    bwr_n = 1'b1; bsel_n = '1;
    op_read(4, "R3"); op_read(6, "R3"); op_read(4, "R3");
    // R4 whole-word override
    addr = AW'(7); wdata = 32'h0F1E2D3C; awr_n = 1'b0; bwr_n = 1'b0; bsel_n = 4'b1110;
    cyc("R4");
    awr_n = 1'b1; bwr_n = 1'b1; bsel_n = '1;
    op_read(7, "R4"); op_read(7, "R4"); op_read(7, "R4");
    // R2 deselected writes and reads
    ce_b = 1'b0; op_write(3, 32'hDEADBEEF, "R2");
    ce_b = 1'b1; ce_a_n = 1'b1; op_write(3, 32'h12345678, "R2");
    ce_a_n = 1'b0; ce_c_n = 1'b1; op_read(3, "R2"); op_read(3, "R2");
    ce_c_n = 1'b0;
    op_read(3, "R2"); op_read(3, "R2"); op_read(3, "R2");
    // R7 deselect turn-off depth
    op_read(9, "R7"); op_read(10, "R7");
    ce_b = 1'b0; cyc("R7"); cyc("R7");
    ce_b = 1'b1; op_read(11, "R7");
    op_write(12, 32'h55AA55AA, "R7"); cyc("R7");
    // R8 asynchronous output enable
    op_read(2, "R8"); op_read(2, "R8");
    oe_n = 1'b1; #1 check_out("R8");
    oe_n = 1'b0; #1 check_out("R8");
    // R9 sleep
    op_read(1, "R9"); op_read(1, "R9");
    slp = 1'b1; #1 check_out("R9");
    op_write(1, 32'hFFFF0000, "R9"); op_read(1, "R9"); cyc("R9");
    slp = 1'b0;
    op_read(1, "R9"); op_read(1, "R9"); op_read(1, "R9");
    // random traffic
    for (int n = 0; n < 400; n++) begin
      int k;
      k = $urandom_range(0, 99);
      addr = AW'($urandom_range(0, 15)); wdata = $urandom();
      awr_n = 1'b1; bwr_n = 1'b1; bsel_n = 4'($urandom());
      ce_a_n = (k < 6); ce_b = !(k >= 6 && k < 10); ce_c_n = (k >= 10 && k < 13);
      if (k >= 50 && k < 62) awr_n = 1'b0;
      else if (k >= 62 && k < 78) bwr_n = 1'b0;
      oe_n = ($urandom_range(0, 9) == 0);
      slp  = ($urandom_range(0, 19) == 0);
      cyc(lt);
    end
    idle_in();
    cyc("R1"); cyc("R1");
  endtask

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0; pipe_sel = 1'b0;
    m_v1 = 1'b0; m_v2 = 1'b0; m_a1 = '0; m_d2 = '0;
    idle_in();
    run_mode(1'b0);
    run_mode(1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog R1: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule